// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This controller sits between an internal request bus that uses a valid/ready handshake and an external 128K x 8 asynchronous static RAM. Each accepted request is a single byte read or write. The controller turns it into a strobe sequence on the memory pins: a chip-enable pair of opposite polarity, an active-low output enable, an active-low write enable, a 17-bit address and an 8-bit data bus. The data bus is split into an input, an output and a drive enable, so that a tri-state pad can sit outside this block.

All of the memory's timing minimums are given as counts of system clock cycles through parameters. One netlist therefore serves any speed grade once the counts are set for the clock in use. The defaults suit a 125 MHz clock and a 55 ns part.

Between accesses the memory is kept deselected, with both strobes high. A read holds output enable low for the access count and samples the bus on the last of those cycles. It then waits out the memory's output-float time before another request can be accepted. A write drives the data for the whole write-enable pulse and for one cycle after it. Completion of either kind of request is signalled with a one-cycle done pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever idle, the controller shows ready high. The first chip enable is high, the second chip enable is low, output enable and write enable are both high, and the data drive enable is low.
- R2: An accepted read selects the chip (first enable low, second high) with output enable low and write enable high for exactly ACC_CYC cycles. The byte on the data input in the last of those cycles is returned on rsp_rdata, and rsp_valid is high ACC_CYC cycles after the accepting edge.
- R3: An accepted write holds write enable low, with the chip selected, for exactly max(WP_CYC, DS_CYC) cycles. The byte the memory captures when write enable rises equals the request's write data.
- R4: The data drive enable is high in every cycle where write enable is low, stays high for exactly one cycle after write enable rises, and is then released.
- R5: The address does not change while write enable is low, or while output enable is low.
- R6: The data drive enable is never high during the HZ_CYC cycles that follow output enable going high.
- R7: rsp_valid is a one-cycle pulse. For a write it is high max(WP_CYC, DS_CYC)+1 cycles after the accepting edge.
- R8: While a request is in progress, ready stays low and no further request is taken.
- R9: Output enable stays high throughout every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | DW | Byte read (valid with a read's done pulse) |
| mem_addr | output | AW | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_o | output | DW | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_i | input | DW | Data from the memory |

## Verification
On every cycle, the assertions check the strobe rules: output enable and write enable never low together, and the chip always selected under either strobe. They also check that the address holds under an active strobe, that data is driven across the whole write pulse, that the bus is not driven inside the float window after a read, and that the done pulse is a single cycle. Only the bench's scenarios can show the rest: that a byte written to a given address, including the lowest and highest, comes back unchanged, and that the read latency and write-pulse length match the parameters exactly. The bench also runs a read directly followed by a write, and in that case confirms that no drive overlaps the memory's own.

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl #(
  parameter int AW      = 17,
  parameter int DW      = 8,
  parameter int ACC_CYC = 7,
  parameter int WP_CYC  = 5,
  parameter int DS_CYC  = 4,
  parameter int WC_CYC  = 7,
  parameter int HZ_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_sel_n,
  output logic          mem_sel,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);
  localparam int WE_LEN  = (WP_CYC > DS_CYC) ? WP_CYC : DS_CYC;
  localparam int REC_LEN = (WC_CYC > WE_LEN + 1) ? WC_CYC - WE_LEN - 1 : 0;
  localparam int MAXC    = (ACC_CYC > WE_LEN) ? ((ACC_CYC > HZ_CYC) ? ACC_CYC : HZ_CYC)
                                              : ((WE_LEN > HZ_CYC) ? WE_LEN : HZ_CYC);
  localparam int CW      = $clog2(MAXC + REC_LEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_RHZ, S_WR, S_WH, S_WREC} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q, rd_q;
  logic          done_q;
  wire           last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          wd_q   <= req_wdata;
          cnt    <= req_write ? CW'(WE_LEN - 1) : CW'(ACC_CYC - 1);
          st     <= req_write ? S_WR : S_RD;
        end
        S_RD: if (last) begin
          rd_q   <= mem_dq_i;
          done_q <= 1'b1;
          cnt    <= CW'(HZ_CYC - 1);
          st     <= S_RHZ;
        end else cnt <= cnt - 1'b1;
        S_RHZ: if (last) st <= S_IDLE; else cnt <= cnt - 1'b1;
        S_WR:  if (last) st <= S_WH;   else cnt <= cnt - 1'b1;
        S_WH: begin
          done_q <= 1'b1;
          cnt    <= CW'((REC_LEN > 0) ? REC_LEN - 1 : 0);
          st     <= (REC_LEN > 0) ? S_WREC : S_IDLE;
        end
        S_WREC: if (last) st <= S_IDLE; else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire selected = (st == S_RD) || (st == S_WR) || (st == S_WH);

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = done_q;
  assign rsp_rdata = rd_q;
  assign mem_addr  = addr_q;
  assign mem_sel_n = !selected;
  assign mem_sel   = selected;
  assign mem_oe_n  = (st != S_RD);
  assign mem_we_n  = (st != S_WR);
  assign mem_dq_o  = wd_q;
  assign mem_dq_oe = (st == S_WR) || (st == S_WH);
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int AW     = 17,
  parameter int HZ_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_sel_n,
  input logic          mem_sel,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_dq_oe
);
  logic [7:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_oe <= 8'(HZ_CYC);
    else if (!mem_oe_n) since_oe <= '0;
    else if (since_oe < 8'(HZ_CYC)) since_oe <= since_oe + 1'b1;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));
  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_sel_n && mem_sel && mem_we_n));
  assert_write_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel));
  assert_write_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  assert_addr_hold_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));
  assert_addr_hold_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> $stable(mem_addr));
  assert_no_drive_in_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && since_oe >= 8'(HZ_CYC)));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_oe_high_in_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.AW(AW), .HZ_CYC(HZ_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sim_sram_async_ctrl.sv
`timescale 1ns/1ps
module sim_sram_async_ctrl;
  localparam int AW = 17, DW = 8;
  localparam int ACC = 7, WP = 5, DS = 4, WC = 7, HZ = 2;
  localparam int WE_LEN = (WP > DS) ? WP : DS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] rsp_rdata, mem_dq_o, mem_dq_i;
  logic [AW-1:0] mem_addr;

  int checks = 0, errors = 0;
  bit [7:0] mem [int];

  always #4 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .ACC_CYC(ACC), .WP_CYC(WP), .DS_CYC(DS),
                    .WC_CYC(WC), .HZ_CYC(HZ)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  wire dev_on = !mem_sel_n && mem_sel && !mem_oe_n && mem_we_n;
  always @(*) mem_dq_i = dev_on ? (mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00) : 8'hzz;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // pin-level monitor: write capture, pulse width, release, bus contention
  bit prev_we = 1'b1, rel_pending = 1'b0;
  int we_run = 0, off_since = 100;
  always @(negedge clk) if (rst_n) begin
    if (!mem_we_n) we_run++;
    if (rel_pending) begin
      chk(!mem_dq_oe, "R4", "drive released after hold", int'(mem_dq_oe), 0);
      rel_pending = 1'b0;
    end
    if (!prev_we && mem_we_n) begin
      chk(we_run == WE_LEN, "R3", "write pulse cycles", we_run, WE_LEN);
      chk(mem_dq_oe, "R4", "drive in hold cycle", int'(mem_dq_oe), 1);
      if (!mem_sel_n && mem_sel) mem[int'(mem_addr)] = mem_dq_o;
      we_run = 0;
      rel_pending = 1'b1;
    end
    if (dev_on) off_since = 0; else if (off_since < 100) off_since++;
    if (mem_dq_oe && off_since <= HZ)
      chk(1'b0, "R6", "drive inside float window", off_since, HZ + 1);
    prev_we = mem_we_n;
  end

  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output int lat, output logic [DW-1:0] rd);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin
      chk(!req_ready, "R8", "ready low while busy", int'(req_ready), 0);
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    @(negedge clk);
    chk(!rsp_valid, "R7", "done is one cycle", int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    chk(req_ready && mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1", "idle pins after reset",
        {req_ready, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat; logic [DW-1:0] rd;
    access(1'b1, a, d, lat, rd);
    chk(lat == WE_LEN + 1, "R7", "write done latency", lat, WE_LEN + 1);
    chk(mem.exists(int'(a)) && mem[int'(a)] == d, "R3", "stored byte",
        mem.exists(int'(a)) ? int'(mem[int'(a)]) : -1, int'(d));
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    int lat; logic [DW-1:0] rd;
    access(1'b0, a, 8'h00, lat, rd);
    chk(lat == ACC, "R2", "read latency", lat, ACC);
    chk(rd === exp, "R2", "read data", int'(rd), int'(exp));
  endtask

  task automatic t_idle_after();
    repeat (HZ + 2) @(negedge clk);
    chk(req_ready && mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe,
        "R1", "standby between accesses",
        {req_ready, mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 6'b110110);
  endtask

  task automatic t_oe_during_write();
    int bad = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00F0F; req_wdata = 8'h3C;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (WE_LEN + 2) begin
      if (!mem_oe_n) bad++;
      @(negedge clk);
    end
    chk(bad == 0, "R9", "output enable low in write", bad, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(17'h00000, 8'h5A);
    t_write(17'h1FFFF, 8'hA5);
    t_write(17'h12345, 8'hFF);
    t_write(17'h0AAAA, 8'h00);
    t_read(17'h00000, 8'h5A);
    t_read(17'h1FFFF, 8'hA5);
    t_read(17'h12345, 8'hFF);
    t_read(17'h0AAAA, 8'h00);
    t_write(17'h12345, 8'h81);
    t_read(17'h12345, 8'h81);
    t_read(17'h00000, 8'h5A);
    t_write(17'h00001, 8'h7E);
    t_read(17'h00001, 8'h7E);
    t_idle_after();
    t_oe_during_write();
    t_read(17'h00F0F, 8'h3C);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule